// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This controller sits between the host's transmit request and the medium's line driver. It limits how long the driver may stay on without a break. It measures continuous transmit activity in ticks of the 10 MHz collision oscillator. When a single burst lasts longer than the allowed on-time, or when a driver fault is sensed, the controller turns the driver off. It then keeps the driver off until the line has been quiet for a long recovery interval.

While the driver is held off, the controller raises a jabber flag. The collision-indicator generator uses this flag to send the oscillator signal back to the host. An external redundant disable, sensed from the driver supply, also raises the flag and blocks the driver for as long as it is present. This input does not change the internal state. The on-time limit and the recovery interval are parameters. Their defaults are 260000 ticks (26 ms) and 4000000 ticks (400 ms).

Top module: `jabber_guard`

## Requirements
- R1: After reset the controller is idle, `drv_en` is 1 and `jab_flag` is 0.
- R2: Counting starts at the clock edge that first sees `tx_active` high; that edge does not count. If `tx_active` then stays high for ON_LIMIT further clock edges with `tick` high, `drv_en` falls to 0 and `jab_flag` rises to 1 after the ON_LIMIT-th of those edges, and not before.
- R3: When `tx_active` drops before the limit, the on-time count returns to zero. Bursts that are each shorter than the limit never trip the controller, however many occur.
- R4: Once tripped, the controller stays disabled with `jab_flag` at 1 for as long as `tx_active` or `drv_fault` stays high.
- R5: The recovery interval starts at the first clock edge that sees both `tx_active` and `drv_fault` low. After QUIET_LEN further tick edges that stay quiet, the controller returns to idle, with `drv_en` at 1 and `jab_flag` at 0.
- R6: If `tx_active` or `drv_fault` goes high during the recovery interval, the controller returns to the disabled state. The recovery count then restarts from zero at the next quiet edge.
- R7: A high `drv_fault` forces `drv_en` to 0 in the same cycle. From the next clock edge it trips the controller, and `jab_flag` stays at 1 until recovery completes.
- R8: A high `ext_disable` forces `drv_en` to 0 and `jab_flag` to 1 in the same cycle and leaves the controller state unchanged. Once it is released, both outputs return to their earlier values at once.
- R9: Edges with `tick` low advance neither the on-time count nor the recovery count.
- R10: Whenever `jab_flag` is 1, `drv_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe from the 10 MHz collision oscillator |
| tx_active | input | 1 | Host data pair is carrying transmit activity |
| drv_fault | input | 1 | Line driver fault sensed |
| ext_disable | input | 1 | External redundant disable sensed on the driver supply |
| drv_en | output | 1 | Line driver enable |
| jab_flag | output | 1 | Jabber active; requests the collision-indicator signal |

## Verification
A controller that trips early or late shows it at `drv_en`. The output falls on a cycle other than the ON_LIMIT-th tick edge of a burst, so the trip edge is checked on both sides: one edge before and the edge itself. A recovery count that is not cleared when the line is disturbed shows as `jab_flag` falling too soon after a restart. An on-time count that survives between bursts shows as a trip partway through a later short burst. The combinational paths for the fault and the external disable are checked in the same cycle the input changes, before any clock edge.

// File: rtl/jabber_guard.sv
module jabber_guard #(
  parameter int ON_LIMIT  = 260000,
  parameter int QUIET_LEN = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_active,
  input  logic drv_fault,
  input  logic ext_disable,
  output logic drv_en,
  output logic jab_flag
);
  localparam int MAXC = (QUIET_LEN > ON_LIMIT) ? QUIET_LEN : ON_LIMIT;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] ON_LAST    = CW'(ON_LIMIT - 1);
  localparam logic [CW-1:0] QUIET_LAST = CW'(QUIET_LEN - 1);

  typedef enum logic [1:0] {IDLE, ACTIVE, JABBED, UNJAB} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  wire tripped = (st == JABBED) || (st == UNJAB);
  wire quiet   = !tx_active && !drv_fault;

  assign drv_en   = !tripped && !drv_fault && !ext_disable;
  assign jab_flag = tripped || ext_disable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE: begin
          cnt <= '0;
          if (drv_fault)      st <= JABBED;
          else if (tx_active) st <= ACTIVE;
        end
        ACTIVE: begin
          if (drv_fault) begin
            st <= JABBED;
          end else if (!tx_active) begin
            st  <= IDLE;
            cnt <= '0;
          end else if (tick) begin
            if (cnt == ON_LAST) begin
              st  <= JABBED;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        JABBED: begin
          cnt <= '0;
          if (quiet) st <= UNJAB;
        end
        default: begin
          if (!quiet) begin
            st  <= JABBED;
            cnt <= '0;
          end else if (tick) begin
            if (cnt == QUIET_LAST) begin
              st  <= IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_jab_blocks_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
    jab_flag |-> !drv_en);

  assert_trip_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ACTIVE && st == JABBED) |-> ($past(cnt) == ON_LAST || $past(drv_fault)));

  assert_release_after_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == UNJAB && st == IDLE) |-> ($past(cnt) == QUIET_LAST && $past(tick)));

  assert_restart_on_noise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == UNJAB && !quiet) |=> (st == JABBED && cnt == '0));

  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && st == ACTIVE && tx_active && !drv_fault) |=> $stable(cnt));

  assert_fault_trips_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_fault |=> jab_flag);
endmodule

// File: tb/jabber_guard_tb.sv
`timescale 1ns/1ps
module jabber_guard_tb_top;
  localparam int ONL = 20;
  localparam int QL  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic tx_active = 1'b0;
  logic drv_fault = 1'b0;
  logic ext_disable = 1'b0;
  logic drv_en, jab_flag;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  jabber_guard #(.ON_LIMIT(ONL), .QUIET_LEN(QL)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_active(tx_active),
    .drv_fault(drv_fault), .ext_disable(ext_disable),
    .drv_en(drv_en), .jab_flag(jab_flag));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 drv_en after reset", drv_en, 1'b1);
    chk("R1 jab_flag after reset", jab_flag, 1'b0);
  endtask

  // raise tx at negedge, trip at ONL-th counted edge
  task automatic do_trip(input string req);
    tx_active = 1'b1;
    edges(ONL);
    chk({req, " drv_en one edge before limit"}, drv_en, 1'b1);
    edges(1);
    chk({req, " drv_en at limit"}, drv_en, 1'b0);
    chk({req, " jab_flag at limit"}, jab_flag, 1'b1);
  endtask

  // quiet from this negedge; release after QL counted edges
  task automatic do_unjab(input string req);
    edges(QL);
    chk({req, " jab_flag one edge before release"}, jab_flag, 1'b1);
    chk({req, " drv_en one edge before release"}, drv_en, 1'b0);
    edges(1);
    chk({req, " jab_flag after release"}, jab_flag, 1'b0);
    chk({req, " drv_en after release"}, drv_en, 1'b1);
  endtask

  task automatic t_short_frames;
    for (int f = 0; f < 3; f++) begin
      tx_active = 1'b1;
      edges(ONL - 5);
      chk("R3 short burst keeps driver on", drv_en, 1'b1);
      tx_active = 1'b0;
      edges(2);
    end
    chk("R3 no jab after short bursts", jab_flag, 1'b0);
  endtask

  task automatic t_trip_and_recover;
    do_trip("R2");
    edges(50);
    chk("R4 held while tx stays active", jab_flag, 1'b1);
    chk("R10 driver off while jabbed", drv_en, 1'b0);
    tx_active = 1'b0;
    do_unjab("R5");
  endtask

  task automatic t_unjab_restart;
    do_trip("R2 second trip");
    tx_active = 1'b0;
    edges(10);
    tx_active = 1'b1;
    edges(1);
    tx_active = 1'b0;
    edges(QL - 5);
    chk("R6 no early release after tx returns", jab_flag, 1'b1);
    drv_fault = 1'b1;
    edges(1);
    drv_fault = 1'b0;
    do_unjab("R6 restart after fault");
  endtask

  task automatic t_fault;
    drv_fault = 1'b1;
    #1;
    chk("R7 fault blocks driver same cycle", drv_en, 1'b0);
    edges(1);
    chk("R7 fault raises jab_flag", jab_flag, 1'b1);
    edges(5);
    chk("R7 jab_flag held during fault", jab_flag, 1'b1);
    drv_fault = 1'b0;
    do_unjab("R7 recovery after fault");
  endtask

  task automatic t_ext;
    ext_disable = 1'b1;
    #1;
    chk("R8 ext disable drv_en", drv_en, 1'b0);
    chk("R8 ext disable jab_flag", jab_flag, 1'b1);
    edges(3);
    ext_disable = 1'b0;
    #1;
    chk("R8 release drv_en", drv_en, 1'b1);
    chk("R8 release jab_flag", jab_flag, 1'b0);
    edges(1);
    chk("R8 state untouched", jab_flag, 1'b0);
  endtask

  task automatic t_tick_gate;
    tick = 1'b0;
    tx_active = 1'b1;
    edges(3 * ONL);
    chk("R9 no count without tick drv_en", drv_en, 1'b1);
    chk("R9 no count without tick jab_flag", jab_flag, 1'b0);
    tx_active = 1'b0;
    tick = 1'b1;
    edges(2);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_short_frames();
    t_trip_and_recover();
    t_unjab_restart();
    t_fault();
    t_ext();
    t_tick_gate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule